// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, every clock, which stages of a five-stage in-order pipeline advance, which hold, where an empty slot is inserted and which instructions are thrown away. The stages are fetch, decode, operand (address calculation and the data memory access), execute and write. There is no forwarding. Registers are written at the end of the write stage and read in decode. The register file returns a value written in the same cycle. Fetch and the operand stage share a single memory port.

The decoder presents the instruction now in decode: its valid bit, destination and two source registers, and whether it reads or writes memory. The controller keeps its own short copy of what sits in the operand and execute stages. The execute stage reports a resolved branch and whether it was taken. Three stage-indexed vectors come out, all combinational from the current state and inputs: hold, bubble and flush. In all three, bit 0 is fetch, bit 1 decode, bit 2 operand, bit 3 execute and bit 4 write.

Top module: `hz_stall_ctrl`

## Requirements
- R1: With an empty pipeline and no valid decode instruction, all three output vectors are zero, including while reset is asserted.
- R2: A decode instruction whose source equals the destination of the instruction directly ahead of it stalls for exactly two cycles. Each stall cycle gives hold=5'b00011, bubble=5'b00100 and flush=0. The third cycle shows no stall.
- R3: A dependency at distance two (one unrelated instruction between) stalls for one cycle. A matching destination that has reached the write stage causes no stall. This applies to either source field.
- R4: Register 0 never creates a dependency, whether it appears as a destination or as a source.
- R5: A valid memory read or write in the operand stage blocks fetch for that cycle only: hold=5'b00001, bubble=5'b00010.
- R6: If a register dependency and a memory conflict occur together, only the dependency pattern is produced (hold=5'b00011, bubble=5'b00100). At most one bubble bit is ever set.
- R7: With branch resolved and taken, flush=5'b00111 and hold=bubble=0, whatever stall would otherwise apply.
- R8: Flushed instructions leave no dependency and no memory conflict behind them in later cycles.
- R9: A branch resolved as not taken flushes nothing and does not change the stall decision.
- R10: Hold bits form a prefix from fetch: decode is held only together with fetch. Operand, execute and write are never held, so register writes complete in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_dst | input | REG_W | Destination register of decode instruction (0 = none) |
| id_src_a | input | REG_W | First source register (0 = none) |
| id_src_b | input | REG_W | Second source register (0 = none) |
| id_mem_rd | input | 1 | Decode instruction will read data memory in the operand stage |
| id_mem_wr | input | 1 | Decode instruction will write data memory in the operand stage |
| br_resolve | input | 1 | Execute stage resolves a branch this cycle |
| br_taken | input | 1 | Resolved branch leaves the sequential path |
| stage_hold | output | 5 | Stage keeps its register this cycle |
| stage_bubble | output | 5 | Stage loads an empty slot this cycle |
| stage_flush | output | 5 | Instruction in stage is discarded |

## Verification
The hardest case to reach is a taken branch in execute while, in the same cycle, a memory instruction sits in the operand stage and decode holds a reader of that instruction's destination. The flush must win, and the discarded instructions must not create stalls afterwards. The stimulus reaches this with three chained instructions timed so the branch resolves exactly then. The next decode instruction then reads both flushed destinations, and any stall would show that flushed instructions survived in the internal copy. A not-taken run of the same sequence shows that the dependency stall appears when no flush takes place.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NUM_STG = 5;
  localparam int S_IF = 0;
  localparam int S_ID = 1;
  localparam int S_OF = 2;
  localparam int S_EX = 3;
  localparam int S_WB = 4;
endpackage

// File: rtl/hz_shadow_pipe.sv
module hz_shadow_pipe #(
  parameter int REG_W = 5,
  parameter int DEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [REG_W-1:0]            in_dst,
  input  logic                        in_mem,
  input  logic [DEPTH-1:0]            kill,
  output logic [DEPTH-1:0]            vld_q,
  output logic [DEPTH-1:0][REG_W-1:0] dst_q,
  output logic                        head_mem_q
);
  logic [DEPTH-1:0]            vld_d;
  logic [DEPTH-1:0][REG_W-1:0] dst_d;
  logic                        head_mem_d;

  always_comb begin
    vld_d[0]   = in_valid & ~kill[0];
    dst_d[0]   = in_dst;
    head_mem_d = in_valid & ~kill[0] & in_mem;
    for (int k = 1; k < DEPTH; k++) begin
      vld_d[k] = vld_q[k-1] & ~kill[k];
      dst_d[k] = dst_q[k-1];
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[k] <= 1'b0;
        dst_q[k] <= '0;
      end else begin
        vld_q[k] <= vld_d[k];
        if (vld_d[k]) dst_q[k] <= dst_d[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) head_mem_q <= 1'b0;
    else        head_mem_q <= head_mem_d;
  end
endmodule

// File: rtl/hz_raw_detect.sv
module hz_raw_detect #(
  parameter int REG_W = 5,
  parameter int NCHK  = 2
) (
  input  logic                       rd_valid,
  input  logic [REG_W-1:0]           src_a,
  input  logic [REG_W-1:0]           src_b,
  input  logic [NCHK-1:0]            wr_vld,
  input  logic [NCHK-1:0][REG_W-1:0] wr_dst,
  output logic                       hit
);
  logic [NCHK-1:0] match;

  for (genvar k = 0; k < NCHK; k++) begin : g_cmp
    logic ma, mb;
    assign ma = (src_a != '0) && (src_a == wr_dst[k]);
    assign mb = (src_b != '0) && (src_b == wr_dst[k]);
    assign match[k] = wr_vld[k] & (ma | mb);
  end

  assign hit = rd_valid & (|match);
endmodule

// File: rtl/hz_priority.sv
module hz_priority #(
  parameter int NUM_STG = 5,
  parameter int BR_STG  = 3,
  parameter int RAW_STG = 1,
  parameter int MEM_STG = 0
) (
  input  logic               flush_req,
  input  logic               raw_hit,
  input  logic               mem_busy,
  output logic [NUM_STG-1:0] hold,
  output logic [NUM_STG-1:0] bubble,
  output logic [NUM_STG-1:0] flush
);
  logic raw_win, mem_win;

  assign raw_win = ~flush_req & raw_hit;
  assign mem_win = ~flush_req & ~raw_hit & mem_busy;

  for (genvar i = 0; i < NUM_STG; i++) begin : g_stg
    localparam bit UP_RAW = (i <= RAW_STG);
    localparam bit UP_MEM = (i <= MEM_STG);
    localparam bit AT_RAW = (i == RAW_STG + 1);
    localparam bit AT_MEM = (i == MEM_STG + 1);
    localparam bit YOUNG  = (i < BR_STG);
    assign hold[i]   = (raw_win & UP_RAW) | (mem_win & UP_MEM);
    assign bubble[i] = (raw_win & AT_RAW) | (mem_win & AT_MEM);
    assign flush[i]  = flush_req & YOUNG;
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl #(
  parameter int REG_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id_valid,
  input  logic [REG_W-1:0]   id_dst,
  input  logic [REG_W-1:0]   id_src_a,
  input  logic [REG_W-1:0]   id_src_b,
  input  logic               id_mem_rd,
  input  logic               id_mem_wr,
  input  logic               br_resolve,
  input  logic               br_taken,
  output logic [4:0]         stage_hold,
  output logic [4:0]         stage_bubble,
  output logic [4:0]         stage_flush
);
  import hz_pkg::*;

  localparam int DEPTH = S_EX - S_OF + 1;

  logic [DEPTH-1:0]            sh_vld;
  logic [DEPTH-1:0][REG_W-1:0] sh_dst;
  logic                        sh_mem;
  logic [DEPTH-1:0]            kill;
  logic                        raw_hit;
  logic                        mem_busy;
  logic                        flush_req;

  for (genvar k = 0; k < DEPTH; k++) begin : g_kill
    assign kill[k] = stage_flush[S_OF + k - 1] | stage_bubble[S_OF + k];
  end

  hz_shadow_pipe #(.REG_W(REG_W), .DEPTH(DEPTH)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (id_valid),
    .in_dst     (id_dst),
    .in_mem     (id_mem_rd | id_mem_wr),
    .kill       (kill),
    .vld_q      (sh_vld),
    .dst_q      (sh_dst),
    .head_mem_q (sh_mem)
  );

  hz_raw_detect #(.REG_W(REG_W), .NCHK(DEPTH)) u_raw (
    .rd_valid (id_valid),
    .src_a    (id_src_a),
    .src_b    (id_src_b),
    .wr_vld   (sh_vld),
    .wr_dst   (sh_dst),
    .hit      (raw_hit)
  );

  assign mem_busy  = sh_vld[0] & sh_mem;
  assign flush_req = br_resolve & br_taken;

  hz_priority #(
    .NUM_STG (NUM_STG),
    .BR_STG  (S_EX),
    .RAW_STG (S_ID),
    .MEM_STG (S_IF)
  ) u_prio (
    .flush_req (flush_req),
    .raw_hit   (raw_hit),
    .mem_busy  (mem_busy),
    .hold      (stage_hold),
    .bubble    (stage_bubble),
    .flush     (stage_flush)
  );
endmodule

// File: rtl/hz_stall_ctrl_chk.sv
module hz_stall_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             id_valid,
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic             br_resolve,
  input logic             br_taken,
  input logic [4:0]       stage_hold,
  input logic [4:0]       stage_bubble,
  input logic [4:0]       stage_flush
);
  assert_hold_prefix_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_hold[1] |-> stage_hold[0]) && (stage_hold[4:2] == 3'b000));

  assert_single_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stage_bubble));

  assert_taken_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_resolve && br_taken) |->
      (stage_flush == 5'b00111 && stage_hold == 5'b0 && stage_bubble == 5'b0));

  assert_no_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_resolve && br_taken) |-> (stage_flush == 5'b0));

  assert_raw_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_bubble[2] && $past(stage_bubble[2])) |=> !stage_bubble[2]);

  assert_reg0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_src_a == '0 && id_src_b == '0) |-> !stage_bubble[2]);

  assert_mem_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stage_bubble[1] |-> (stage_hold[0] && !stage_hold[1]));
endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .id_valid     (id_valid),
  .id_src_a     (id_src_a),
  .id_src_b     (id_src_b),
  .br_resolve   (br_resolve),
  .br_taken     (br_taken),
  .stage_hold   (stage_hold),
  .stage_bubble (stage_bubble),
  .stage_flush  (stage_flush)
);

// File: tb/hz_stall_ctrl_test.sv
`timescale 1ns/100ps
module hz_stall_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       id_valid;
  logic [4:0] id_dst, id_src_a, id_src_b;
  logic       id_mem_rd, id_mem_wr;
  logic       br_resolve, br_taken;
  logic [4:0] stage_hold, stage_bubble, stage_flush;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  hz_stall_ctrl #(.REG_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_dst(id_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_mem_rd(id_mem_rd),
    .id_mem_wr(id_mem_wr), .br_resolve(br_resolve), .br_taken(br_taken),
    .stage_hold(stage_hold), .stage_bubble(stage_bubble), .stage_flush(stage_flush)
  );

  always #2.5 clk = ~clk;

  localparam logic [4:0] H_RAW = 5'b00011, B_RAW = 5'b00100;
  localparam logic [4:0] H_MEM = 5'b00001, B_MEM = 5'b00010;

  task automatic expect3(input string req, input logic [4:0] h, input logic [4:0] b,
                         input logic [4:0] f);
    checks++;
    if (stage_hold !== h || stage_bubble !== b || stage_flush !== f) begin
      errors++;
      $display("FAIL %s: hold=%b bubble=%b flush=%b expected hold=%b bubble=%b flush=%b",
               req, stage_hold, stage_bubble, stage_flush, h, b, f);
    end
  endtask

  task automatic put(input logic v, input logic [4:0] d, input logic [4:0] sa,
                     input logic [4:0] sb, input logic rd, input logic wr);
    id_valid = v; id_dst = d; id_src_a = sa; id_src_b = sb;
    id_mem_rd = rd; id_mem_wr = wr;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    br_resolve = 1'b0; br_taken = 1'b0;
  endtask

  task automatic drain();
    put(0, 0, 0, 0, 0, 0); step();
    put(0, 0, 0, 0, 0, 0); step();
  endtask

  task automatic t_reset();
    expect3("R1 during reset", 5'b0, 5'b0, 5'b0);
    @(negedge clk); rst_n = 1'b1;
    step();
    put(0, 0, 0, 0, 0, 0);
    expect3("R1 after reset", 5'b0, 5'b0, 5'b0);
  endtask

  task automatic t_raw_adjacent();
    put(1, 5'd3, 5'd1, 5'd2, 0, 0);
    expect3("R2 writer enters", 5'b0, 5'b0, 5'b0); step();
    put(1, 5'd0, 5'd3, 5'd0, 0, 0);
    expect3("R2 stall cycle one", H_RAW, B_RAW, 5'b0); step();
    put(1, 5'd0, 5'd3, 5'd0, 0, 0);
    expect3("R2 stall cycle two R10", H_RAW, B_RAW, 5'b0); step();
    put(1, 5'd0, 5'd3, 5'd0, 0, 0);
    expect3("R3 writer in write stage, no stall", 5'b0, 5'b0, 5'b0); step();
    drain();
  endtask

  task automatic t_raw_gap();
    put(1, 5'd4, 5'd0, 5'd0, 0, 0); step();
    put(1, 5'd6, 5'd7, 5'd8, 0, 0);
    expect3("R3 unrelated middle", 5'b0, 5'b0, 5'b0); step();
    put(1, 5'd0, 5'd9, 5'd4, 0, 0);
    expect3("R3 distance two on src_b stalls", H_RAW, B_RAW, 5'b0); step();
    put(1, 5'd0, 5'd9, 5'd4, 0, 0);
    expect3("R3 distance two one cycle only", 5'b0, 5'b0, 5'b0); step();
    drain();
  endtask

  task automatic t_reg_zero();
    put(1, 5'd0, 5'd1, 5'd1, 0, 0); step();
    put(1, 5'd0, 5'd0, 5'd0, 0, 0);
    expect3("R4 register 0 no dependency", 5'b0, 5'b0, 5'b0); step();
    drain();
  endtask

  task automatic t_mem_port();
    put(1, 5'd0, 5'd0, 5'd0, 1, 0); step();
    put(1, 5'd0, 5'd1, 5'd2, 0, 0);
    expect3("R5 read in operand stage blocks fetch", H_MEM, B_MEM, 5'b0); step();
    put(0, 5'd0, 5'd0, 5'd0, 0, 0);
    expect3("R5 block lasts one cycle", 5'b0, 5'b0, 5'b0); step();
    drain();
    put(1, 5'd0, 5'd0, 5'd0, 0, 1); step();
    put(1, 5'd0, 5'd1, 5'd2, 0, 0);
    expect3("R5 write in operand stage blocks fetch", H_MEM, B_MEM, 5'b0); step();
    put(1, 5'd0, 5'd1, 5'd2, 0, 0);
    expect3("R5 write block lasts one cycle", 5'b0, 5'b0, 5'b0); step();
    drain();
  endtask

  task automatic t_combined();
    put(1, 5'd5, 5'd0, 5'd0, 1, 0); step();
    put(1, 5'd0, 5'd5, 5'd0, 0, 0);
    expect3("R6 dependency beats memory conflict", H_RAW, B_RAW, 5'b0); step();
    put(1, 5'd0, 5'd5, 5'd0, 0, 0);
    expect3("R6 second stall cycle", H_RAW, B_RAW, 5'b0); step();
    put(1, 5'd0, 5'd5, 5'd0, 0, 0);
    expect3("R6 released", 5'b0, 5'b0, 5'b0); step();
    drain();
  endtask

  task automatic t_branch(input logic taken);
    put(1, 5'd9, 5'd0, 5'd0, 0, 0); step();
    put(1, 5'd12, 5'd0, 5'd0, 1, 0); step();
    put(1, 5'd13, 5'd12, 5'd0, 0, 0);
    br_resolve = 1'b1; br_taken = taken; #1;
    if (taken) begin
      expect3("R7 taken branch flush overrides stall", 5'b0, 5'b0, 5'b00111); step();
      put(1, 5'd0, 5'd12, 5'd13, 0, 0);
      expect3("R8 flushed instructions leave no trace", 5'b0, 5'b0, 5'b0); step();
    end else begin
      expect3("R9 not taken keeps stall, no flush", H_RAW, B_RAW, 5'b0); step();
    end
    drain();
  endtask

  initial begin
    rst_n = 1'b0; br_resolve = 1'b0; br_taken = 1'b0;
    put(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    t_reset();
    t_raw_adjacent();
    t_raw_gap();
    t_reg_zero();
    t_mem_port();
    t_combined();
    t_branch(1'b1);
    t_branch(1'b0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: timed out, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule